// File: doc/BRIEF.md
# Machine Check Error Bank

This block is one hardware error-reporting bank. Error sources offer one event per cycle. Each event carries these fields:

- a correctable/uncorrectable flag
- a 16-bit error code
- a physical address, with a qualifier that says whether the address is known
- a flag that marks the event as coming from a speculative load

The bank folds accepted events into a 64-bit status word and a separate address register. It records whether a second error arrived while a record was still held. Once it holds an uncorrectable error, that record is frozen.

Software reads both registers at the outputs. It rewrites them through a small write port, normally by writing zero to the status word before the next error. Each captured uncorrectable error raises a one-cycle exception pulse for the logic above.

There are two resets. A cold (power-on) reset empties the bank. A warm reset only quiets the block: the logged record survives it, so it can be read after the system restarts.

Top module: `mc_err_bank`

## Requirements
- R1: While `cold_rst_n` is low, the status word, the address register and `mce_pulse` all clear to zero at the next clock edge.
- R2: An accepted event on an empty bank is visible in the cycle after it is presented. The status word then reads as follows:
  - bit 63 (valid) is 1
  - bit 62 (overflow) is 0
  - bit 61 is the uncorrectable flag
  - bit 58 (address known) is `evt_addr_ok`
  - bits 15:0 hold the error code
  - every other bit is 0
- R3: An accepted event that arrives while bit 63 is set sets bit 62. This includes the case where the held error is uncorrectable.
- R4: While the held record is uncorrectable (bits 63 and 61 both set), no later event changes any status bit other than bit 62. The error code bits 15:0 are included in this. No later event changes the address register either.
- R5: While a correctable record is held, an accepted event replaces it. The replacing event may be correctable or uncorrectable. The new record takes the R2 layout, except that bit 62 is set.
- R6: A correctable event with `evt_spec` set is ignored and changes neither register. An uncorrectable event with `evt_spec` set is accepted.
- R7: When a record is written, the address register is loaded only if `evt_addr_ok` is 1. If `evt_addr_ok` is 0, bit 58 is written as 0 and the address register keeps its value.
- R8: While `rst_n` is low:
  - events and software writes are ignored;
  - the status word and the address register keep their values;
  - `mce_pulse` is 0 in the following cycle.
- R9: A software write behaves according to `sw_wr_sel`:
  - with `sw_wr_sel`=0, the status word takes `sw_wr_data`;
  - with `sw_wr_sel`=1, the address register takes the low `ADDR_W` bits of `sw_wr_data`.
  If an accepted event arrives in the same cycle, it takes priority. For a status write, the event is logged as a fresh R2 record with bit 62 clear.
- R10: `mce_pulse` is 1 for exactly the one cycle after an uncorrectable event is written as a new record, either fresh or replacing a correctable one. The pulse does not occur when the event only sets overflow on a held uncorrectable record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, synchronous, active low; empties the bank |
| rst_n | input | 1 | Warm reset, synchronous, active low; keeps the logged record |
| evt_valid | input | 1 | An error event is offered this cycle |
| evt_uncorr | input | 1 | The event is uncorrectable |
| evt_spec | input | 1 | The event comes from a speculative load |
| evt_code | input | CODE_W | Error code |
| evt_addr_ok | input | 1 | `evt_addr` holds a valid physical address |
| evt_addr | input | ADDR_W | Physical address of the error |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_sel | input | 1 | Write target: 0 selects the status word, 1 selects the address register |
| sw_wr_data | input | 64 | Software write data |
| status_q | output | 64 | Status word |
| addr_q | output | ADDR_W | Address register |
| mce_pulse | output | 1 | One-cycle machine-check exception pulse |

## Verification
All three results are registered, so each one is due exactly one clock edge after the inputs that cause it. This covers the status word, the address register and the exception pulse. The bench drives new inputs one time step after a rising edge and applies its model update at the next rising edge. It compares the outputs one time step after that edge, so each check sees the result of exactly one cycle's stimulus. Ignored stimulus (speculative correctable events, warm reset, events on a frozen record) is checked by observing that the registers read the same in the following cycle.

// File: rtl/mcb_pkg.sv
// Package: shared bit positions and widths for the machine check error bank.
// Assumes a 64-bit status word; field positions are fixed because software
// decodes them.
package mcb_pkg;
    localparam int STAT_W    = 64;
    localparam int BIT_VALID = 63;
    localparam int BIT_OVF   = 62;
    localparam int BIT_UC    = 61;
    localparam int BIT_ADDRV = 58;
    localparam int CODE_LSB  = 0;
endpackage

// File: rtl/mcb_filter.sv
// Module: mcb_filter
// Decides which inputs of this cycle may act on the bank. Correctable events
// from speculative loads are dropped. Nothing acts while the warm reset is low.
// Assumes sw_wr_sel picks exactly one target per write.
module mcb_filter (
    input  logic rst_n,
    input  logic evt_valid,
    input  logic evt_uncorr,
    input  logic evt_spec,
    input  logic sw_wr_en,
    input  logic sw_wr_sel,
    output logic accept,
    output logic st_wr,
    output logic ad_wr
);
    // Gate events and writes by warm reset and the speculative filter.
    always_comb begin
        accept = rst_n && evt_valid && !(evt_spec && !evt_uncorr);
        st_wr  = rst_n && sw_wr_en && !sw_wr_sel;
        ad_wr  = rst_n && sw_wr_en && sw_wr_sel;
    end
endmodule

// File: rtl/mcb_update.sv
// Module: mcb_update
// Computes the next bank contents from the current record, the filtered event
// and the software write. The rules are:
//  - an accepted event always wins over a software write in the same cycle;
//  - a held uncorrectable record only gains the overflow flag;
//  - a held correctable record is replaced, with overflow set.
// Assumes ADDR_W <= 64 and CODE_W <= 58.
module mcb_update #(
    parameter int CODE_W = 16,
    parameter int ADDR_W = 40
) (
    input  logic [63:0]       cur_status,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              accept,
    input  logic              st_wr,
    input  logic              ad_wr,
    input  logic [63:0]       sw_data,
    input  logic              evt_uncorr,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              evt_addr_ok,
    input  logic [ADDR_W-1:0] evt_addr,
    output logic [63:0]       nxt_status,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              cap_unc
);
    import mcb_pkg::*;

    logic              held_valid;
    logic              held_unc;
    logic              write_new;
    logic              new_ovf;
    logic [63:0]       record;

    // Classify the record currently held in the bank.
    always_comb begin
        held_valid = cur_status[BIT_VALID];
        held_unc   = held_valid && cur_status[BIT_UC];
    end

    // Build the fresh record image for the offered event.
    always_comb begin
        record = '0;
        record[BIT_VALID] = 1'b1;
        record[BIT_OVF]   = new_ovf;
        record[BIT_UC]    = evt_uncorr;
        record[BIT_ADDRV] = evt_addr_ok;
        record[CODE_LSB +: CODE_W] = evt_code;
    end

    // Pick between software write, fresh capture, replacement and overflow.
    always_comb begin
        nxt_status = cur_status;
        nxt_addr   = cur_addr;
        write_new  = 1'b0;
        new_ovf    = 1'b0;
        if (ad_wr) nxt_addr = sw_data[ADDR_W-1:0];
        if (st_wr) nxt_status = sw_data;
        if (accept) begin
            if (st_wr || !held_valid) begin
                write_new = 1'b1;
            end else if (held_unc) begin
                nxt_status[BIT_OVF] = 1'b1;
            end else begin
                write_new = 1'b1;
                new_ovf   = 1'b1;
            end
            if (write_new) begin
                nxt_status = record;
                if (evt_addr_ok) nxt_addr = evt_addr;
            end
        end
        cap_unc = accept && write_new && evt_uncorr;
    end
endmodule

// File: rtl/mcb_regs.sv
// Module: mcb_regs
// Holds the status word and the address register, and registers the exception
// pulse. The record is cleared only by the cold reset; the warm reset clears
// only the pulse, so a logged error survives it.
module mcb_regs #(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_n,
    input  logic [63:0]       nxt_status,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic              cap_unc,
    output logic [63:0]       status_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              mce_pulse
);
    // Record storage, emptied only at power-on.
    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            status_q <= '0;
            addr_q   <= '0;
        end else begin
            status_q <= nxt_status;
            addr_q   <= nxt_addr;
        end
    end

    // One-cycle exception pulse, quiet under either reset.
    always_ff @(posedge clk) begin
        if (!cold_rst_n || !rst_n) mce_pulse <= 1'b0;
        else                       mce_pulse <= cap_unc;
    end
endmodule

// File: rtl/mc_err_bank.sv
// Module: mc_err_bank (top)
// A single machine check error-reporting bank. It filters incoming error
// events, folds them into a status word and an address register under
// overflow and freeze rules, and signals uncorrectable captures upward.
// Assumes at most one event per cycle; arbitration among sources sits above.
module mc_err_bank #(
    parameter int CODE_W = 16,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_uncorr,
    input  logic              evt_spec,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              evt_addr_ok,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              sw_wr_en,
    input  logic              sw_wr_sel,
    input  logic [63:0]       sw_wr_data,
    output logic [63:0]       status_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              mce_pulse
);
    logic              accept;
    logic              st_wr;
    logic              ad_wr;
    logic [63:0]       nxt_status;
    logic [ADDR_W-1:0] nxt_addr;
    logic              cap_unc;

    mcb_filter u_filter (
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_uncorr (evt_uncorr),
        .evt_spec   (evt_spec),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_sel  (sw_wr_sel),
        .accept     (accept),
        .st_wr      (st_wr),
        .ad_wr      (ad_wr)
    );

    mcb_update #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_update (
        .cur_status  (status_q),
        .cur_addr    (addr_q),
        .accept      (accept),
        .st_wr       (st_wr),
        .ad_wr       (ad_wr),
        .sw_data     (sw_wr_data),
        .evt_uncorr  (evt_uncorr),
        .evt_code    (evt_code),
        .evt_addr_ok (evt_addr_ok),
        .evt_addr    (evt_addr),
        .nxt_status  (nxt_status),
        .nxt_addr    (nxt_addr),
        .cap_unc     (cap_unc)
    );

    mcb_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .rst_n      (rst_n),
        .nxt_status (nxt_status),
        .nxt_addr   (nxt_addr),
        .cap_unc    (cap_unc),
        .status_q   (status_q),
        .addr_q     (addr_q),
        .mce_pulse  (mce_pulse)
    );
endmodule

// File: rtl/mc_err_bank_checker.sv
// Module: mc_err_bank_checker
// Temporal checks on the bank's ports, bound into every instance of the top.
module mc_err_bank_checker #(
    parameter int CODE_W = 16,
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              cold_rst_n,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              evt_uncorr,
    input logic              evt_spec,
    input logic              sw_wr_en,
    input logic [63:0]       status_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              mce_pulse
);
    logic acc;
    logic held_unc;

    // Port-level view of an event that should take effect.
    always_comb begin
        acc      = rst_n && evt_valid && !(evt_spec && !evt_uncorr);
        held_unc = status_q[63] && status_q[61];
    end

    // R3: a second error while valid sets overflow.
    a_r3_overflow_on_repeat: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (acc && status_q[63] && !sw_wr_en) |=> status_q[62]);

    // R4: a held uncorrectable record keeps its code, flags and address.
    a_r4_unc_frozen: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (held_unc && !sw_wr_en) |=>
            ($stable(status_q[61:0] & ~(64'h1 << 62)) && $stable(addr_q) && status_q[63]));

    // R6: speculative correctable events leave the bank untouched.
    a_r6_spec_dropped: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (evt_valid && evt_spec && !evt_uncorr && !sw_wr_en) |=>
            ($stable(status_q) && $stable(addr_q)));

    // R8: warm reset keeps the logged record.
    a_r8_warm_hold: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !rst_n |=> ($stable(status_q) && $stable(addr_q) && !mce_pulse));

    // R10: a pulse follows only an uncorrectable event and lasts one cycle.
    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!cold_rst_n)
        mce_pulse |-> ($past(evt_valid && evt_uncorr) && status_q[61]));
endmodule

bind mc_err_bank mc_err_bank_checker #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_uncorr (evt_uncorr),
    .evt_spec   (evt_spec),
    .sw_wr_en   (sw_wr_en),
    .status_q   (status_q),
    .addr_q     (addr_q),
    .mce_pulse  (mce_pulse)
);

// File: tb/mc_err_bank_test.sv
// Bench: directed corner cases followed by seeded random traffic, compared
// each cycle against a behavioural model written from the requirements.
module mc_err_bank_test;
    localparam int CODE_W = 16;
    localparam int ADDR_W = 40;

    logic              clk = 1'b0;
    logic              cold_rst_n = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_valid = 1'b0;
    logic              evt_uncorr = 1'b0;
    logic              evt_spec = 1'b0;
    logic [CODE_W-1:0] evt_code = '0;
    logic              evt_addr_ok = 1'b0;
    logic [ADDR_W-1:0] evt_addr = '0;
    logic              sw_wr_en = 1'b0;
    logic              sw_wr_sel = 1'b0;
    logic [63:0]       sw_wr_data = '0;
    logic [63:0]       status_q;
    logic [ADDR_W-1:0] addr_q;
    logic              mce_pulse;

    int checks = 0;
    int fails  = 0;

    logic [63:0]       m_stat = '0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic              m_pulse = 1'b0;

    always #5 clk = ~clk;

    mc_err_bank #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_uncorr(evt_uncorr), .evt_spec(evt_spec),
        .evt_code(evt_code), .evt_addr_ok(evt_addr_ok), .evt_addr(evt_addr),
        .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
        .status_q(status_q), .addr_q(addr_q), .mce_pulse(mce_pulse)
    );

    // Expected status word for a freshly written record (R2 layout).
    function automatic logic [63:0] rec(input logic uc, input logic aok,
                                        input logic [15:0] code, input logic ovf);
        logic [63:0] r;
        r = 64'h0;
        r[63] = 1'b1;
        r[62] = ovf;
        r[61] = uc;
        r[58] = aok;
        r[15:0] = code;
        return r;
    endfunction

    // Apply one clock of the requirement model to m_stat, m_addr and m_pulse.
    task automatic model_step();
        logic take;
        logic fresh;
        logic repl;
        logic [63:0] s;
        logic [ADDR_W-1:0] a;
        s = m_stat;
        a = m_addr;
        if (!cold_rst_n) begin
            m_stat = '0; m_addr = '0; m_pulse = 1'b0;
            return;
        end
        if (!rst_n) begin
            m_pulse = 1'b0;
            return;
        end
        take  = evt_valid && (evt_uncorr || !evt_spec);
        fresh = take && ((sw_wr_en && !sw_wr_sel) || !m_stat[63]);
        repl  = take && !fresh && !m_stat[61];
        if (sw_wr_en && sw_wr_sel)  a = sw_wr_data[ADDR_W-1:0];
        if (sw_wr_en && !sw_wr_sel) s = sw_wr_data;
        if (take && !fresh && !repl) s[62] = 1'b1;
        if (fresh || repl) begin
            s = rec(evt_uncorr, evt_addr_ok, evt_code, repl);
            if (evt_addr_ok) a = evt_addr;
        end
        m_pulse = (fresh || repl) && evt_uncorr;
        m_stat = s;
        m_addr = a;
    endtask

    // Compare one observed value with the expected one.
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one cycle, update the model and check all outputs.
    task automatic cyc(input string req);
        @(posedge clk);
        model_step();
        #1;
        chk({req, " status"}, status_q, m_stat);
        chk({req, " addr"}, {{(64-ADDR_W){1'b0}}, addr_q}, {{(64-ADDR_W){1'b0}}, m_addr});
        chk({req, " pulse"}, {63'h0, mce_pulse}, {63'h0, m_pulse});
    endtask

    // Return all stimulus inputs to idle.
    task automatic idle();
        evt_valid = 0; evt_uncorr = 0; evt_spec = 0; evt_addr_ok = 0;
        sw_wr_en = 0; sw_wr_sel = 0; sw_wr_data = '0;
    endtask

    // Drive one error event.
    task automatic ev(input logic uc, input logic sp, input logic [15:0] code,
                      input logic aok, input logic [ADDR_W-1:0] ad);
        evt_valid = 1; evt_uncorr = uc; evt_spec = sp; evt_code = code;
        evt_addr_ok = aok; evt_addr = ad;
    endtask

    // Drive a software write of the status word (sel=0) or address (sel=1).
    task automatic sw(input logic sel, input logic [63:0] d);
        sw_wr_en = 1; sw_wr_sel = sel; sw_wr_data = d;
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        int r;
        seed = 32'd1729;
        r = $urandom(seed);
        #1;
        cyc("R1"); cyc("R1");
        chk("R1 status zero", status_q, 64'h0);
        cold_rst_n = 1; rst_n = 1;
        cyc("R1");

        // R2 fresh correctable capture with address (R7 address loaded)
        ev(0, 0, 16'h1234, 1, 40'hAB_CDEF_0123); cyc("R2");
        chk("R2 layout", status_q, 64'h8400_0000_0000_1234);
        idle();
        // R5 replace held correctable; R7 no address keeps register
        ev(0, 0, 16'h0055, 0, 40'h11); cyc("R5");
        chk("R5 replaced with ovf", status_q, rec(0, 0, 16'h0055, 1));
        chk("R7 address kept", {24'h0, addr_q}, 64'hAB_CDEF_0123);
        idle();
        // R9 clear by writing zero
        sw(0, 64'h0); cyc("R9");
        chk("R9 cleared", status_q, 64'h0);
        idle();
        // R10 uncorrectable fresh capture gives a pulse
        ev(1, 0, 16'h0077, 1, 40'h22); cyc("R10");
        chk("R10 pulse high", {63'h0, mce_pulse}, 64'h1);
        idle(); cyc("R10");
        chk("R10 pulse one cycle", {63'h0, mce_pulse}, 64'h0);
        // R3 and R4: later error on frozen record only adds overflow
        ev(0, 0, 16'h0099, 1, 40'h33); cyc("R3");
        chk("R4 frozen with ovf", status_q, rec(1, 1, 16'h0077, 1));
        chk("R4 address frozen", {24'h0, addr_q}, 64'h22);
        ev(1, 0, 16'h00AA, 1, 40'h44); cyc("R4");
        chk("R10 no pulse on frozen", {63'h0, mce_pulse}, 64'h0);
        idle();
        // R6 speculative correctable ignored, speculative uncorrectable taken
        sw(0, 64'h0); cyc("R6");
        idle();
        ev(0, 1, 16'h0101, 1, 40'h55); cyc("R6");
        chk("R6 spec correctable ignored", status_q, 64'h0);
        ev(1, 1, 16'h0202, 0, 40'h66); cyc("R6");
        chk("R6 spec uncorrectable taken", status_q, rec(1, 0, 16'h0202, 0));
        idle();
        // R8 warm reset keeps the record and drops events
        rst_n = 0; ev(0, 0, 16'h0303, 1, 40'h77); cyc("R8"); cyc("R8");
        chk("R8 record held", status_q, rec(1, 0, 16'h0202, 0));
        idle(); rst_n = 1; cyc("R8");
        // R9 event wins over simultaneous zero write, logged fresh
        ev(0, 0, 16'h0404, 1, 40'h88); cyc("R9");
        sw(0, 64'h0); ev(0, 0, 16'h0505, 0, 40'h99); cyc("R9");
        chk("R9 event wins fresh", status_q, rec(0, 0, 16'h0505, 0));
        idle();
        sw(1, 64'h12_3456_789A); cyc("R9");
        chk("R9 address write", {24'h0, addr_q}, 64'h12_3456_789A);
        idle();

        // Seeded random traffic checked against the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            idle();
            rst_n = ($urandom % 40) != 0;
            if ($urandom % 3 != 0)
                ev($urandom % 3 == 0, $urandom % 4 == 0, 16'($urandom),
                   $urandom % 2 == 0, {8'($urandom), 32'($urandom)});
            if ($urandom % 6 == 0)
                sw($urandom % 2, ($urandom % 2) ? 64'h0 : {32'($urandom), 32'($urandom)});
            cyc("RAND");
        end
        rst_n = 1; idle();
        cyc("RAND");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule